// File: doc/BRIEF.md
# Prioritised CPU Interrupt Line Controller

This block sits between a set of CPU interrupt request lines and the core's trap logic. Each line can be enabled or masked, set to follow its input (level) or to latch a rising edge until software acknowledges it (edge), and given a priority from 0 to 15. A global threshold register masks every line whose priority falls below it. Among the lines left standing, the highest priority wins and a tie goes to the lowest line number. The block raises one request output and presents the winning line number beside it.

Software reaches the controls through a simple word-addressed register port. Writes take effect at the clock edge and reads are combinational. A handler can support nested preemption: on entry it writes its own priority plus one into the threshold, so only strictly higher lines can interrupt it, and on exit it restores the previous threshold.

Top module: `irq_line_ctl`

## Requirements
- R1: After reset all enables, trigger types, priorities and the threshold read as zero, no line is pending, and irq_req is low.
- R2: Word 0 is the enable register. Bit n enables line n for n from 1 to 31. Bit 0 always reads 0. A disabled line never wins.
- R3: Word 1 is the trigger-type register. Bit n selects level triggering for line n when 0 and edge triggering when 1. Bit 0 reads 0.
- R4: A level-type line is pending exactly while its input is high, and this reaches irq_req and irq_id in the same cycle with no clock edge in between.
- R5: An edge-type line latches pending at the clock edge where its input is first seen high after being low. It stays pending after the input drops.
- R6: Word 2 is write-one-to-clear. Writing 1 in bit n drops the latched pending state of line n at that clock edge. If a new rising edge arrives in the same cycle, the edge wins. The word reads as 0.
- R7: Line n's priority is at word 32+n and is held in the low 4 bits of the write data. It reads back zero-extended. Priority 0 means the line never interrupts.
- R8: Word 3 holds an 8-bit threshold that reads back in the low 8 bits. A line whose priority is below the threshold cannot win, so a threshold of 16 or more masks every line.
- R9: Among pending, enabled and admitted lines, the line with the highest priority wins. Among equal priorities, the lowest line number wins.
- R10: irq_req is high exactly when some line is eligible. While irq_req is high, irq_id is the winning line number. While it is low, irq_id is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (6) | Word address for reads and writes |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Combinational read data for reg_addr |
| irq_lines | input | LINES (31), bits 31..1 | Interrupt request inputs, bit n is line n |
| irq_req | output | 1 | Interrupt request to the core |
| irq_id | output | ID_W (5) | Number of the winning line |

## Verification
The assertions assume that the request inputs are synchronous to clk and held low while reset is asserted. They also assume that register writes come one at a time through the single write strobe. With those assumptions, a fall of a latched edge bit can only come from a clear write, and a winner can always be traced back to one eligible line.

The bench drives every input change on the falling clock edge and keeps all inputs low through reset. It sweeps pseudo-random line patterns under several thresholds with level triggering, and covers edge triggering with directed pulses, including a clear that lands in the same cycle as a new edge.

// File: rtl/irq_line_ctl_pkg.sv
package irq_line_ctl_pkg;
  localparam int PRIO_W        = 4;
  localparam int THR_W         = 8;
  localparam int ADR_ENABLE    = 0;
  localparam int ADR_TYPE      = 1;
  localparam int ADR_CLEAR     = 2;
  localparam int ADR_THRESH    = 3;
  localparam int ADR_PRIO_BASE = 32;

  // a line may compete only with a nonzero priority at or above threshold
  function automatic logic prio_admitted(logic [PRIO_W-1:0] p, logic [THR_W-1:0] thr);
    return (p != '0) && (THR_W'(p) >= thr);
  endfunction

  // used while scanning from the highest line number downward:
  // equal priority replaces, so the lowest number survives a tie
  function automatic logic takes_over(logic [PRIO_W-1:0] cand, logic [PRIO_W-1:0] best);
    return cand >= best;
  endfunction
endpackage

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
  import irq_line_ctl_pkg::*;
#(
  parameter int LINES  = 31,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  output logic [LINES:1]                en_q,
  output logic [LINES:1]                type_q,
  output logic [LINES:1]                clr_hit,
  output logic [THR_W-1:0]              thr_q,
  output logic [LINES:1][PRIO_W-1:0]    prio_q
);
  logic hit_en, hit_type, hit_clr, hit_thr;
  assign hit_en   = we && (addr == ADDR_W'(ADR_ENABLE));
  assign hit_type = we && (addr == ADDR_W'(ADR_TYPE));
  assign hit_clr  = we && (addr == ADDR_W'(ADR_CLEAR));
  assign hit_thr  = we && (addr == ADDR_W'(ADR_THRESH));

  assign clr_hit = hit_clr ? wdata[LINES:1] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      type_q <= '0;
      thr_q  <= '0;
    end else begin
      if (hit_en)   en_q   <= wdata[LINES:1];
      if (hit_type) type_q <= wdata[LINES:1];
      if (hit_thr)  thr_q  <= wdata[THR_W-1:0];
    end
  end

  for (genvar n = 1; n <= LINES; n++) begin : g_prio
    logic [PRIO_W-1:0] pr_r;
    always_ff @(posedge clk) begin
      if (!rst_n)
        pr_r <= '0;
      else if (we && (addr == ADDR_W'(ADR_PRIO_BASE + n)))
        pr_r <= wdata[PRIO_W-1:0];
    end
    assign prio_q[n] = pr_r;
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(ADR_ENABLE)) rdata = DATA_W'({en_q, 1'b0});
    if (addr == ADDR_W'(ADR_TYPE))   rdata = DATA_W'({type_q, 1'b0});
    if (addr == ADDR_W'(ADR_THRESH)) rdata = DATA_W'(thr_q);
    for (int n = 1; n <= LINES; n++)
      if (addr == ADDR_W'(ADR_PRIO_BASE + n)) rdata = DATA_W'(prio_q[n]);
  end
endmodule

// File: rtl/irq_ctl_pending.sv
module irq_ctl_pending #(
  parameter int LINES = 31
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [LINES:1] irq_lines,
  input  logic [LINES:1] type_q,
  input  logic [LINES:1] clr_hit,
  output logic [LINES:1] pend,
  output logic [LINES:1] edge_pend,
  output logic [LINES:1] rise
);
  for (genvar n = 1; n <= LINES; n++) begin : g_line
    logic prev_r, edge_r;
    assign rise[n] = type_q[n] && irq_lines[n] && !prev_r;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_r <= 1'b0;
        edge_r <= 1'b0;
      end else begin
        prev_r <= irq_lines[n];
        if (rise[n])         edge_r <= 1'b1;
        else if (clr_hit[n]) edge_r <= 1'b0;
      end
    end
    assign edge_pend[n] = edge_r;
    assign pend[n]      = type_q[n] ? edge_r : irq_lines[n];
  end
endmodule

// File: rtl/irq_ctl_arbiter.sv
module irq_ctl_arbiter
  import irq_line_ctl_pkg::*;
#(
  parameter int LINES = 31,
  localparam int ID_W = $clog2(LINES + 1)
) (
  input  logic [LINES:1]             pend,
  input  logic [LINES:1]             en_q,
  input  logic [LINES:1][PRIO_W-1:0] prio_q,
  input  logic [THR_W-1:0]           thr_q,
  output logic [LINES:1]             elig,
  output logic                       req,
  output logic [ID_W-1:0]            win_id,
  output logic [PRIO_W-1:0]          win_prio
);
  for (genvar n = 1; n <= LINES; n++) begin : g_elig
    assign elig[n] = pend[n] && en_q[n] && prio_admitted(prio_q[n], thr_q);
  end

  always_comb begin
    win_id   = '0;
    win_prio = '0;
    for (int n = LINES; n >= 1; n--) begin
      if (elig[n] && takes_over(prio_q[n], win_prio)) begin
        win_id   = ID_W'(n);
        win_prio = prio_q[n];
      end
    end
  end

  assign req = |elig;
endmodule

// File: rtl/irq_line_ctl.sv
module irq_line_ctl
  import irq_line_ctl_pkg::*;
#(
  parameter int LINES  = 31,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  localparam int ID_W  = $clog2(LINES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [LINES:1]    irq_lines,
  output logic              irq_req,
  output logic [ID_W-1:0]   irq_id
);
  logic [LINES:1]             en_w, type_w, clr_w, pend_w, edge_pend_w, rise_w, elig_w;
  logic [LINES:1][PRIO_W-1:0] prio_w;
  logic [THR_W-1:0]           thr_w;
  logic [PRIO_W-1:0]          win_prio_w;

  irq_ctl_regs #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .en_q(en_w), .type_q(type_w), .clr_hit(clr_w),
    .thr_q(thr_w), .prio_q(prio_w)
  );

  irq_ctl_pending #(.LINES(LINES)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .type_q(type_w),
    .clr_hit(clr_w), .pend(pend_w), .edge_pend(edge_pend_w), .rise(rise_w)
  );

  irq_ctl_arbiter #(.LINES(LINES)) u_arb (
    .pend(pend_w), .en_q(en_w), .prio_q(prio_w), .thr_q(thr_w),
    .elig(elig_w), .req(irq_req), .win_id(irq_id), .win_prio(win_prio_w)
  );
endmodule

// File: rtl/irq_line_ctl_chk.sv
module irq_line_ctl_chk
  import irq_line_ctl_pkg::*;
#(
  parameter int LINES = 31,
  parameter int ID_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_req,
  input logic [ID_W-1:0]   irq_id,
  input logic [LINES:1]    elig,
  input logic [LINES:1]    edge_pend,
  input logic [LINES:1]    clr_hit,
  input logic [LINES:1]    rise,
  input logic [LINES:1]    en,
  input logic [THR_W-1:0]  thr,
  input logic [PRIO_W-1:0] win_prio
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) !rst_n |=> (edge_pend == '0 && en == '0));

  // R10
  req_iff_elig_chk: assert property (@(posedge clk) disable iff (!rst_n) irq_req == (elig != '0));

  // R10
  winner_elig_chk: assert property (@(posedge clk) disable iff (!rst_n) irq_req |-> elig[irq_id]);

  // R8
  winner_admitted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (win_prio != '0 && THR_W'(win_prio) >= thr));

  // R2
  idle_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n) (en == '0) |-> !irq_req);

  for (genvar n = 1; n <= LINES; n++) begin : g_line
    // R5
    edge_latches_chk: assert property (@(posedge clk) disable iff (!rst_n) rise[n] |=> edge_pend[n]);
    // R6
    drop_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(edge_pend[n]) |-> $past(clr_hit[n]));
  end
endmodule

bind irq_line_ctl irq_line_ctl_chk #(.LINES(LINES), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_id(irq_id), .elig(elig_w),
  .edge_pend(edge_pend_w), .clr_hit(clr_w), .rise(rise_w), .en(en_w),
  .thr(thr_w), .win_prio(win_prio_w)
);

// File: tb/irq_line_ctl_bench.sv
`timescale 1ns/1ps
module irq_line_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:1] irq_lines = '0;
  logic        irq_req;
  logic [4:0]  irq_id;

  irq_line_ctl u_irq_line_ctl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_lines(irq_lines),
    .irq_req(irq_req), .irq_id(irq_id)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit reported = 0;
  int prio_m [32];
  logic [31:0] en_m = '0;
  int thr_m = 0;
  logic [31:0] lfsr = 32'h1234_5679;

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    reg_addr = 6'(a);
    #1 d = reg_rdata;
  endtask

  function automatic int exp_winner(logic [31:1] lv);
    int best = 0, bp = 0;
    for (int n = 1; n <= 31; n++)
      if (lv[n] && en_m[n] && prio_m[n] != 0 && prio_m[n] >= thr_m && prio_m[n] > bp) begin
        best = n; bp = prio_m[n];
      end
    return best;
  endfunction

  function automatic logic [31:0] step(logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic level_sweep(string tag, int count);
    for (int k = 0; k < count; k++) begin
      logic [31:1] pat;
      int w;
      lfsr = step(lfsr);
      pat = (k % 3 == 0) ? (lfsr[31:1] & step(lfsr)[31:1] & {lfsr[15:0], lfsr[31:17]}) : lfsr[31:1];
      @(negedge clk);
      irq_lines = pat;
      #1;
      w = exp_winner(pat);
      chk({tag, " req"}, int'(irq_req), int'(w != 0));
      chk({tag, " id"}, int'(irq_id), w);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] d;
    int thr_list [6] = '{0, 1, 5, 9, 15, 16};
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin rd(a, d); chk("R1 reg", int'(d), 0); end
    for (int n = 1; n <= 31; n++) begin rd(32 + n, d); chk("R1 prio", int'(d), 0); end
    chk("R1 irq_req", int'(irq_req), 0);

    // R2 enable register, bit 0 stays zero
    wr(0, 32'hFFFF_FFFF); en_m = 32'hFFFF_FFFE;
    rd(0, d); chk("R2 enable readback", int'(d), int'(32'hFFFF_FFFE));

    // R7 priorities, upper write bits dropped; lines 11 and 27 end at 0
    for (int n = 1; n <= 31; n++) begin
      prio_m[n] = (n * 7 + 3) & 15;
      wr(32 + n, 32'(prio_m[n] | 32'hF0));
    end
    for (int n = 1; n <= 31; n++) begin rd(32 + n, d); chk("R7 prio readback", int'(d), prio_m[n]); end

    // R8 threshold keeps 8 bits
    wr(3, 32'h1A5); rd(3, d); chk("R8 thresh readback", int'(d), 'hA5);

    // R3 all lines level
    wr(1, 32'h0); rd(1, d); chk("R3 type readback", int'(d), 0);

    // R4 R8 R9 R10 level sweeps across thresholds
    foreach (thr_list[i]) begin
      thr_m = thr_list[i];
      wr(3, 32'(thr_m));
      level_sweep("R9 R8 R4 sweep", 200);
    end

    // R2 partial enables
    thr_m = 0; wr(3, 0);
    en_m = 32'h5555_AAAA & 32'hFFFF_FFFE; wr(0, en_m);
    level_sweep("R2 masked sweep", 150);
    en_m = 32'hFFFF_FFFE; wr(0, en_m);

    // R7 priority-0 line alone never wins
    @(negedge clk) irq_lines = 31'(1) << 10;
    #1 chk("R7 prio0 line", int'(irq_req), 0);
    @(negedge clk) irq_lines = '0;

    // R3 R5 edge mode for all lines
    wr(1, 32'hFFFF_FFFE); rd(1, d); chk("R3 type edge readback", int'(d), int'(32'hFFFF_FFFE));
    @(negedge clk) irq_lines = 31'(1) << 19;   // line 20, prio 15
    #1 chk("R5 not before edge", int'(irq_req), 0);
    @(negedge clk) chk("R5 latched id", int'(irq_id), 20);
    irq_lines = '0;
    @(negedge clk) chk("R5 held after drop", int'(irq_id), 20);
    chk("R5 held req", int'(irq_req), 1);

    // R8 threshold above all priorities
    wr(3, 16); chk("R8 thr16 masks", int'(irq_req), 0);
    wr(3, 15); chk("R8 thr15 admits", int'(irq_id), 20);
    wr(3, 0);

    // R6 clear
    wr(2, 32'(1) << 20);
    chk("R6 cleared", int'(irq_req), 0);
    rd(2, d); chk("R6 clear reads 0", int'(d), 0);

    // R6 edge and clear in the same cycle: edge wins
    @(negedge clk);
    irq_lines = 31'(1) << 19; reg_we = 1'b1; reg_addr = 6'd2; reg_wdata = 32'(1) << 20;
    @(negedge clk);
    reg_we = 1'b0; irq_lines = '0;
    chk("R6 edge beats clear", int'(irq_id), 20);
    wr(2, 32'(1) << 20); chk("R6 cleared again", int'(irq_req), 0);

    // R9 tie among edges: lines 4 and 20 both priority 15
    @(negedge clk) irq_lines = (31'(1) << 3) | (31'(1) << 19);
    @(negedge clk) irq_lines = '0;
    chk("R9 tie lowest", int'(irq_id), 4);
    wr(2, 32'(1) << 4); chk("R9 next winner", int'(irq_id), 20);
    wr(2, 32'(1) << 20); chk("R10 none id", int'(irq_id), 0);

    // R4 a level line among edge lines
    wr(1, 32'hFFFF_FFFE & ~(32'(1) << 5));
    @(negedge clk) irq_lines = 31'(1) << 4;   // line 5, prio 6
    #1 chk("R4 level immediate", int'(irq_id), 5);
    @(negedge clk) irq_lines = '0;
    #1 chk("R4 level drop", int'(irq_req), 0);

    // R2 disabled line never wins
    wr(0, 32'hFFFF_FFFE & ~(32'(1) << 5));
    @(negedge clk) irq_lines = 31'(1) << 4;
    #1 chk("R2 disabled", int'(irq_req), 0);
    @(negedge clk) irq_lines = '0;

    report();
  end
endmodule